// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the 32-bit program counter of a processor with fixed-length, word-aligned 32-bit instructions. On every cycle it works out which address to fetch next. It takes the instruction word now being executed, a two-bit class that the decoder supplies, and the two source register values that the register file supplies. The result is presented combinationally on `next_pc_o`. The counter register loads that value on a rising clock edge when `advance` is high.

Three kinds of next address are formed. A sequential step adds four bytes. A conditional branch adds a signed word offset to the address of the following instruction. A jump keeps the top four bits of the following instruction's address and replaces the rest with a 26-bit word index, so a jump never leaves the current 256 MB region. All arithmetic wraps modulo 2^32. The block does not report overflow.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads the parameter `RESET_VEC` (default 0x0040_0000), and `pc_o` shows it after that edge.
- R2: When `advance` is low and `rst` is low, the counter keeps its value across the edge, whatever the other inputs are.
- R3: When `cls` is 0 (sequential), `next_pc_o` equals `pc_o + 4`, and an advancing edge loads it.
- R4: When `cls` is 1 (branch if equal) and `rs_val == rt_val`, `next_pc_o` equals `pc_o + 4 + (sign-extended instr[15:0] << 2)`. When the two values differ, it equals `pc_o + 4`.
- R5: When `cls` is 2 (branch if not equal) and `rs_val != rt_val`, `next_pc_o` is the branch target of R4. When the two values are equal, it equals `pc_o + 4`.
- R6: The branch offset in instr[15:0] is a signed word count. An offset of -1 (0xFFFF) gives `next_pc_o == pc_o`, and 0x8000 steps back 32768 words from `pc_o + 4`.
- R7: When `cls` is 3 (jump), `next_pc_o` equals `{(pc_o+4)[31:28], instr[25:0], 2'b00}`. The region bits come from `pc_o + 4`, not from `pc_o`.
- R8: Address sums wrap modulo 2^32. A sequential step from 0xFFFF_FFFC gives 0, and a negative branch offset taken near 0 gives an address near the top of the space.
- R9: Bits [1:0] of `pc_o` are always 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | Load the next address on this edge |
| cls | input | 2 | Instruction class: 0 sequential, 1 branch if equal, 2 branch if not equal, 3 jump |
| instr | input | 32 | Current instruction word; immediate in [15:0], jump index in [25:0] |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Selected next fetch address |

## Verification
The hardest situations to reach from the ports are the ones at the edges of the address space. One is the wrap from 0xFFFF_FFFC to 0. The other is a jump whose region bits change because `pc_o + 4` crosses into a new 256 MB region. The counter can only be moved by the block's own instructions, so the stimulus steers it there step by step:
- A jump to index 0 takes the counter to address 0.
- A branch with offset -2 then takes it to 0xFFFF_FFFC.
- From there, a sequential step and a jump each check the wrap.
- A jump to index 0x3FF_FFFF reaches 0x0FFF_FFFC. A following jump must then take its region bits from 0x1000_0000.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
  localparam int XLEN     = 32;
  localparam int IMM_W    = 16;
  localparam int JIDX_W   = 26;
  localparam int REGION_W = XLEN - JIDX_W - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  typedef enum logic [1:0] {
    CLS_SEQ = 2'd0,
    CLS_BEQ = 2'd1,
    CLS_BNE = 2'd2,
    CLS_JMP = 2'd3
  } pc_class_e;

  function automatic logic [XLEN-1:0] seq_step(input logic [XLEN-1:0] pc);
    return pc + STEP;
  endfunction

  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] link,
                                                 input logic [IMM_W-1:0] imm);
    logic [XLEN-1:0] ofs;
    ofs = {{(XLEN-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    return link + ofs;
  endfunction

  function automatic logic [XLEN-1:0] region_target(input logic [XLEN-1:0] link,
                                                    input logic [JIDX_W-1:0] idx);
    return {link[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction
endpackage

// File: rtl/pcn_target_gen.sv
module pcn_target_gen
  import pcn_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] seq_addr,
  output logic [XLEN-1:0] br_addr,
  output logic [XLEN-1:0] jmp_addr
);
  always_comb begin
    seq_addr = seq_step(pc);
    br_addr  = rel_target(seq_addr, instr[IMM_W-1:0]);
    jmp_addr = region_target(seq_addr, instr[JIDX_W-1:0]);
  end
endmodule

// File: rtl/pcn_branch_eval.sv
module pcn_branch_eval
  import pcn_pkg::*;
(
  input  pc_class_e       cls,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            taken
);
  logic same;
  always_comb begin
    same = (rs_val == rt_val);
    unique case (cls)
      CLS_BEQ: taken = same;
      CLS_BNE: taken = !same;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcn_pc_reg.sv
module pcn_pc_reg
  import pcn_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= {RESET_VEC[XLEN-1:2], 2'b00};
    else if (load) q <= {d[XLEN-1:2], 2'b00};
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcn_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        advance,
  input  logic [1:0]  cls,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc_o,
  output logic [31:0] next_pc_o
);
  pc_class_e       cls_e;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] br_addr;
  logic [XLEN-1:0] jmp_addr;
  logic            br_taken;
  logic [XLEN-1:0] sel_next;

  assign cls_e = pc_class_e'(cls);

  pcn_target_gen u_tgt (
    .pc(pc_q), .instr(instr),
    .seq_addr(seq_addr), .br_addr(br_addr), .jmp_addr(jmp_addr)
  );

  pcn_branch_eval u_cmp (
    .cls(cls_e), .rs_val(rs_val), .rt_val(rt_val), .taken(br_taken)
  );

  always_comb begin
    if (cls_e == CLS_JMP) sel_next = jmp_addr;
    else if (br_taken)    sel_next = br_addr;
    else                  sel_next = seq_addr;
  end

  pcn_pc_reg #(.RESET_VEC(RESET_VEC)) u_reg (
    .clk(clk), .rst(rst), .load(advance), .d(sel_next), .q(pc_q)
  );

  assign pc_o      = pc_q;
  assign next_pc_o = sel_next;
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic        advance,
  input logic [1:0]  cls,
  input logic [31:0] pc_q,
  input logic [31:0] seq_addr,
  input logic [31:0] sel_next,
  input logic        br_taken
);
  AST_RESET_VEC: assert property (@(posedge clk) rst |=> pc_q == RESET_VEC); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(pc_q)); // R2
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (advance && cls == 2'd0) |=> pc_q == $past(pc_q) + 32'd4); // R3
  AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (cls inside {2'd1, 2'd2} && !br_taken) |-> sel_next == seq_addr); // R4
  AST_JMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (advance && cls == 2'd3) |=> pc_q[31:28] == $past(seq_addr[31:28])); // R7
  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00); // R9
endmodule

bind pc_next_unit pc_next_unit_chk #(.RESET_VEC(RESET_VEC)) i_chk (
  .clk(clk), .rst(rst), .advance(advance), .cls(cls), .pc_q(pc_q),
  .seq_addr(seq_addr), .sel_next(sel_next), .br_taken(br_taken)
);

// File: tb/test_pc_next_unit.sv
module test_pc_next_unit;
  localparam logic [31:0] VEC = 32'h0040_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic advance = 1'b0;
  logic [1:0] cls = 2'd0;
  logic [31:0] instr = '0, rs_val = '0, rt_val = '0;
  logic [31:0] pc_o, next_pc_o;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] mpc;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pc_next_unit #(.RESET_VEC(VEC)) i_pc_next_unit (
    .clk(clk), .rst(rst), .advance(advance), .cls(cls), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .pc_o(pc_o), .next_pc_o(next_pc_o)
  );

  function automatic logic [31:0] model_next(logic [31:0] pc, logic [1:0] c,
                                             logic [31:0] ins, logic [31:0] a,
                                             logic [31:0] b);
    longint signed words;
    logic [31:0] link;
    link = pc + 32'd4;
    words = longint'($signed(ins[15:0]));
    if (c == 2'd3) return {link[31:28], ins[25:0], 2'b00};
    if ((c == 2'd1 && a == b) || (c == 2'd2 && a != b))
      return 32'(longint'(link) + words * 4);
    return link;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit r, bit adv, logic [1:0] c,
                      logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    logic [31:0] e;
    rst = r; advance = adv; cls = c; instr = ins; rs_val = a; rt_val = b;
    #1;
    e = model_next(mpc, c, ins, a, b);
    if (!r) check({tag, " next"}, next_pc_o, e);
    mpc = r ? VEC : (adv ? e : mpc);
    exp_q.push_back(mpc);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #3;
      if (exp_q.size() != 0) check({tag_q.pop_front(), " pc"}, pc_o, exp_q.pop_front());
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected <= 5000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin : driver
    mpc = 32'hx;
    @(negedge clk);
    step("R1 reset", 1, 0, 2'd0, 32'h0, 0, 0);
    step("R3 seq", 0, 1, 2'd0, 32'hFFFF_FFFF, 1, 2);
    step("R2 hold", 0, 0, 2'd3, 32'h0000_1234, 0, 0);
    step("R4 beq taken", 0, 1, 2'd1, 32'h1000_0003, 7, 7);
    step("R4 beq not taken", 0, 1, 2'd1, 32'h0000_0005, 7, 8);
    step("R5 bne taken self-loop R6", 0, 1, 2'd2, 32'h0000_FFFF, 1, 9);
    step("R5 bne not taken", 0, 1, 2'd2, 32'h0000_0040, 3, 3);
    step("R6 most negative", 0, 1, 2'd1, 32'h0000_8000, 0, 0);
    step("R7 jump to zero", 0, 1, 2'd3, 32'h0800_0000, 0, 0);
    step("R8 branch below zero", 0, 1, 2'd1, 32'h0000_FFFE, 5, 5);
    step("R8 R7 jump with wrapped link", 0, 1, 2'd3, 32'h0000_0005, 0, 0);
    step("R8 back to top", 0, 1, 2'd2, 32'h0000_FFF9, 1, 0);
    step("R8 seq wrap", 0, 1, 2'd0, 32'h0, 0, 0);
    step("R7 jump region end", 0, 1, 2'd3, 32'h03FF_FFFF, 0, 0);
    step("R7 region from link", 0, 1, 2'd3, 32'h0000_0010, 0, 0);
    step("R2 hold again", 0, 0, 2'd0, 32'h0, 0, 0);
    step("R9 aligned seq", 0, 1, 2'd0, 32'h0, 0, 0);
    step("R1 reset again", 1, 1, 2'd3, 32'h0000_0001, 0, 0);
    step("R3 seq after reset", 0, 1, 2'd0, 32'h0, 0, 0);
    @(posedge clk); #5;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule